// File: doc/BRIEF.md
# Pending Interrupt Number Resolver

This block turns a set of pending-interrupt words into one interrupt number. It takes a basic pending word and two 32-bit bank pending words. It picks the single source that a fixed search order ranks first and presents that source as a flat 7-bit number with a valid flag. Both outputs are registered. Masking and enabling are done before this block, so every set bit it sees is treated as a live request.

The basic word carries three kinds of bits. Eight are local sources. Two are summary bits, one for each bank. Eleven are shortcut copies of selected bank sources. The search runs through five stages in order. First come the local sources. Next are the bank-one shortcuts, then the bank-two shortcuts. After those, the full bank-one word is scanned, and last the full bank-two word. In each full-bank scan the sources already covered by shortcuts are left out. A full bank is scanned only when its summary bit is set. In the flat numbering, local sources are 0 to 7, bank one starts at 8 and bank two starts at 40.

Top module: `pend_resolver`

## Requirements
- R1: While reset is asserted, the valid output is 0 and the number output is 0, whatever the inputs.
- R2: The outputs show the result for the inputs sampled at the previous rising clock edge, and they do not change between edges.
- R3: Bits 31:21 of the basic word are ignored. When bits 20:0 are all zero, the result is "none".
- R4: If any of basic bits 7:0 is set, the result is the index of the lowest set bit among them, whatever else is pending.
- R5: Otherwise, basic bits 10..14 are checked from bit 10 upward. They stand for bank-one sources 7, 9, 10, 18 and 19 in that order. The first set bit gives 8 plus that source index.
- R6: Otherwise, basic bits 15..20 are checked from bit 15 upward. They stand for bank-two sources 21, 22, 23, 24, 25 and 30 in that order. The first set bit gives 40 plus that source index.
- R7: Otherwise, if basic bit 8 is set, the bank-one word has bits 7, 9, 10, 18 and 19 cleared. The lowest remaining set bit gives 8 plus its index. When basic bit 8 is clear, the bank-one word has no effect.
- R8: Otherwise, if basic bit 9 is set, the bank-two word has bits 21 to 25 and bit 30 cleared. The lowest remaining set bit gives 40 plus its index. When basic bit 9 is clear, the bank-two word has no effect.
- R9: When no stage finds a source, including when a summary bit is set but its masked bank word is empty, the valid output is 0 and the number output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| basicPend | input | 32 | Basic pending word: locals, summaries and shortcuts |
| bankOnePend | input | 32 | Bank-one pending word |
| bankTwoPend | input | 32 | Bank-two pending word |
| irqValid | output | 1 | High when a source was found |
| irqNum | output | 7 | Flat number of the chosen source, 0 when none |

## Verification
The assertions assume the inputs hold steady from one clock edge to the next. They also assume that a summary bit and its bank word can disagree: a summary bit may be set with an empty masked word, and a bank word may be non-zero with its summary bit clear. The stimulus changes inputs only on the falling edge, so each value is settled at the capturing edge. The stimulus also builds both kinds of disagreement on purpose, alongside exhaustive sweeps of the local bits and the shortcut bits, so the fall-through paths between stages are exercised.

// File: rtl/pendres_pkg.sv
package pendres_pkg;
  localparam int LOCAL_W    = 8;
  localparam int BANK_W     = 32;
  localparam int SC1_N      = 5;
  localparam int SC2_N      = 6;
  localparam int SUM1_POS   = LOCAL_W;
  localparam int SUM2_POS   = LOCAL_W + 1;
  localparam int SC1_LO     = LOCAL_W + 2;
  localparam int SC2_LO     = SC1_LO + SC1_N;
  localparam int BASIC_USED = SC2_LO + SC2_N;
  localparam int BANK1_BASE = LOCAL_W;
  localparam int BANK2_BASE = BANK1_BASE + BANK_W;
  localparam int NUM_SRC    = BANK2_BASE + BANK_W;
  localparam int NUM_W      = $clog2(NUM_SRC);
  localparam int BANK_IDX_W = $clog2(BANK_W);

  typedef struct packed {
    logic localHit;
    logic sc1Hit;
    logic sc2Hit;
    logic bank1Hit;
    logic bank2Hit;
  } stageHit_t;

  typedef struct packed {
    logic pickLocal;
    logic pickSc1;
    logic pickSc2;
    logic pickBank1;
    logic pickBank2;
  } pickStrobe_t;

  // bank source index mirrored by shortcut slot k of the given bank
  function automatic int scSrc(input int bank, input int k);
    int r;
    r = 0;
    if (bank == 0) begin
      case (k)
        0: r = 7;
        1: r = 9;
        2: r = 10;
        3: r = 18;
        default: r = 19;
      endcase
    end else begin
      r = (k < 5) ? 21 + k : 30;
    end
    return r;
  endfunction

  function automatic int scCount(input int bank);
    return (bank == 0) ? SC1_N : SC2_N;
  endfunction

  function automatic logic [BANK_W-1:0] scMask(input int bank);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int k = 0; k < scCount(bank); k++) m[scSrc(bank, k)] = 1'b1;
    return m;
  endfunction

  function automatic bit isShortcut(input int bank, input int idx);
    bit r;
    r = 1'b0;
    for (int k = 0; k < scCount(bank); k++) if (scSrc(bank, k) == idx) r = 1'b1;
    return r;
  endfunction

  function automatic int bankBase(input int bank);
    return BANK1_BASE + bank * BANK_W;
  endfunction
endpackage

// File: rtl/pendres_lowset.sv
module pendres_lowset #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pendres_dp.sv
module pendres_dp
  import pendres_pkg::*;
#(
  parameter int BASIC_IN_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BASIC_IN_W-1:0] basicIn,
  input  logic [BANK_W-1:0]     bank1In,
  input  logic [BANK_W-1:0]     bank2In,
  input  pickStrobe_t           strobe,
  output stageHit_t             hit,
  output logic [NUM_W-1:0]      numQ
);
  localparam int SC_IDX_W = 3;

  logic [BASIC_USED-1:0] basicUsed;
  assign basicUsed = basicIn[BASIC_USED-1:0];

  // local sources
  logic                    localFound;
  logic [$clog2(LOCAL_W)-1:0] localIdx;
  pendres_lowset #(.W(LOCAL_W)) uLocal (
    .vec(basicUsed[LOCAL_W-1:0]), .found(localFound), .idx(localIdx));

  // shortcut slots, lowest slot first
  logic                sc1Found, sc2Found;
  logic [SC_IDX_W-1:0] sc1Slot, sc2Slot;
  pendres_lowset #(.W(SC1_N), .IDX_W(SC_IDX_W)) uSc1 (
    .vec(basicUsed[SC1_LO +: SC1_N]), .found(sc1Found), .idx(sc1Slot));
  pendres_lowset #(.W(SC2_N), .IDX_W(SC_IDX_W)) uSc2 (
    .vec(basicUsed[SC2_LO +: SC2_N]), .found(sc2Found), .idx(sc2Slot));

  logic [NUM_W-1:0] sc1Num, sc2Num;
  always_comb begin
    sc1Num = NUM_W'(BANK1_BASE + scSrc(0, int'(sc1Slot)));
    sc2Num = NUM_W'(BANK2_BASE + scSrc(1, int'(sc2Slot)));
  end

  // full bank scans with shortcut sources removed
  logic [1:0]       bankHitV;
  logic [NUM_W-1:0] bankNum [2];

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [BANK_W-1:0]     word;
    logic [BANK_W-1:0]     masked;
    logic                  found;
    logic [BANK_IDX_W-1:0] idx;
    assign word   = (b == 0) ? bank1In : bank2In;
    assign masked = word & ~scMask(b);
    pendres_lowset #(.W(BANK_W)) uFind (.vec(masked), .found(found), .idx(idx));
    assign bankHitV[b] = basicUsed[SUM1_POS + b] & found;
    assign bankNum[b]  = NUM_W'(bankBase(b)) + NUM_W'(idx);
  end

  always_comb begin
    hit.localHit = localFound;
    hit.sc1Hit   = sc1Found;
    hit.sc2Hit   = sc2Found;
    hit.bank1Hit = bankHitV[0];
    hit.bank2Hit = bankHitV[1];
  end

  logic [NUM_W-1:0] nextNum;
  always_comb begin
    nextNum = ({NUM_W{strobe.pickLocal}} & NUM_W'(localIdx))
            | ({NUM_W{strobe.pickSc1}}   & sc1Num)
            | ({NUM_W{strobe.pickSc2}}   & sc2Num)
            | ({NUM_W{strobe.pickBank1}} & bankNum[0])
            | ({NUM_W{strobe.pickBank2}} & bankNum[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) numQ <= '0;
    else       numQ <= nextNum;
  end

  // R4: a pending local source always wins the control's choice
  assert_local_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|basicUsed[LOCAL_W-1:0]) |-> strobe.pickLocal);

  // R4: a local pick lands in the local range one cycle later
  assert_local_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickLocal |=> (numQ < NUM_W'(LOCAL_W)));

  // R6: bank-two shortcut picks land at or above the bank-two base
  assert_sc2_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickSc2 |=> (numQ >= NUM_W'(BANK2_BASE)));

  // R7: the bank-one scan is never chosen without its summary bit
  assert_summary_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !basicUsed[SUM1_POS] |-> !strobe.pickBank1);

  // R7: a bank-one scan result is inside bank one and never a shortcut source
  assert_bank1_noshort_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickBank1 |=> (numQ >= NUM_W'(BANK1_BASE) && numQ < NUM_W'(BANK2_BASE)
                          && !isShortcut(0, int'(numQ) - BANK1_BASE)));

  // R8: the bank-two scan is never chosen without its summary bit
  assert_summary_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !basicUsed[SUM2_POS] |-> !strobe.pickBank2);
endmodule

// File: rtl/pendres_ctrl.sv
module pendres_ctrl
  import pendres_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stageHit_t   hit,
  output pickStrobe_t strobe,
  output logic        validQ
);
  always_comb begin
    strobe = '0;
    if (hit.localHit)      strobe.pickLocal = 1'b1;
    else if (hit.sc1Hit)   strobe.pickSc1   = 1'b1;
    else if (hit.sc2Hit)   strobe.pickSc2   = 1'b1;
    else if (hit.bank1Hit) strobe.pickBank1 = 1'b1;
    else if (hit.bank2Hit) strobe.pickBank2 = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= |strobe;
  end

  // R2: any stage hit shows up as valid on the next cycle
  assert_hit_to_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hit != '0) |=> validQ);

  // R9: with no stage hit, valid is low on the next cycle
  assert_nohit_invalid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hit == '0) |=> !validQ);
endmodule

// File: rtl/pend_resolver.sv
module pend_resolver
  import pendres_pkg::*;
#(
  parameter int BASIC_IN_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BASIC_IN_W-1:0] basicPend,
  input  logic [BANK_W-1:0]     bankOnePend,
  input  logic [BANK_W-1:0]     bankTwoPend,
  output logic                  irqValid,
  output logic [NUM_W-1:0]      irqNum
);
  stageHit_t   hit;
  pickStrobe_t strobe;

  pendres_dp #(.BASIC_IN_W(BASIC_IN_W)) uDp (
    .clk(clk), .rstN(rstN), .basicIn(basicPend), .bank1In(bankOnePend),
    .bank2In(bankTwoPend), .strobe(strobe), .hit(hit), .numQ(irqNum));

  pendres_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hit(hit), .strobe(strobe), .validQ(irqValid));

  // R9: the number register reads zero whenever valid is low
  assert_none_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqNum == '0));

  // R3: an all-zero used field of the basic word gives no valid result
  assert_idle_basic_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|basicPend[BASIC_USED-1:0]) |-> !irqValid);
endmodule

// File: tb/pend_resolver_test.sv
module pend_resolver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] basicPend = '0;
  logic [31:0] bankOnePend = '0;
  logic [31:0] bankTwoPend = '0;
  logic        irqValid;
  logic [6:0]  irqNum;

  int checks = 0;
  int fails  = 0;
  logic prevV = 1'b0;
  int   prevN = 0;

  always #5 clk = ~clk;

  pend_resolver uut (
    .clk(clk), .rstN(rstN), .basicPend(basicPend), .bankOnePend(bankOnePend),
    .bankTwoPend(bankTwoPend), .irqValid(irqValid), .irqNum(irqNum));

  function automatic int sc1L(input int k);
    int t[5] = '{7, 9, 10, 18, 19};
    return t[k];
  endfunction
  function automatic int sc2L(input int k);
    int t[6] = '{21, 22, 23, 24, 25, 30};
    return t[k];
  endfunction

  function automatic void refModel(input logic [31:0] b, w1, w2,
                                   output logic v, output int n);
    bit done;
    logic [31:0] m1, m2;
    v = 1'b0; n = 0; done = 1'b0;
    m1 = w1; m2 = w2;
    for (int k = 0; k < 5; k++) m1[sc1L(k)] = 1'b0;
    for (int k = 0; k < 6; k++) m2[sc2L(k)] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (!done && b[i]) begin done = 1'b1; n = i; end
    for (int k = 0; k < 5; k++)
      if (!done && b[10 + k]) begin done = 1'b1; n = 8 + sc1L(k); end
    for (int k = 0; k < 6; k++)
      if (!done && b[15 + k]) begin done = 1'b1; n = 40 + sc2L(k); end
    if (b[8])
      for (int i = 0; i < 32; i++)
        if (!done && m1[i]) begin done = 1'b1; n = 8 + i; end
    if (b[9])
      for (int i = 0; i < 32; i++)
        if (!done && m2[i]) begin done = 1'b1; n = 40 + i; end
    v = done;
  endfunction

  task automatic check(input string tag, input logic ev, input int en);
    checks++;
    if (irqValid !== ev || int'(irqNum) !== en) begin
      fails++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               tag, irqValid, irqNum, ev, en);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input logic [31:0] b, w1, w2, input string tag);
    logic ev;
    int   en;
    basicPend = b; bankOnePend = w1; bankTwoPend = w2;
    #1;
    check("R2 hold before edge", prevV, prevN);
    @(negedge clk);
    refModel(b, w1, w2, ev, en);
    check(tag, ev, en);
    prevV = ev; prevN = en;
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low with active inputs
    basicPend = 32'h001F_FFFF; bankOnePend = '1; bankTwoPend = '1;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 0);
    rstN = 1'b1;

    // R4: every local pattern, with deeper stages also pending
    for (int p = 0; p < 256; p++)
      apply({11'h0, 13'h1FFF, p[7:0]}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 local sweep");

    // R5/R6: every shortcut pattern with locals quiet
    for (int p = 0; p < 2048; p++)
      apply({11'h0, p[10:0], 2'b11, 8'h00}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 R6 shortcut sweep");

    // R7: each single bank-one source through the summary path
    for (int i = 0; i < 32; i++)
      apply(32'h0000_0100, 32'h1 << i, 32'h0, "R7 bank one single");
    // R8: each single bank-two source through the summary path
    for (int i = 0; i < 32; i++)
      apply(32'h0000_0300, 32'h0, 32'h1 << i, "R8 bank two single");

    // R3: upper basic bits alone give none
    apply(32'hFFE0_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 upper bits ignored");
    apply(32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 zero basic");
    // R7: bank-one word ignored without its summary bit
    apply(32'h0000_0000 | 32'h0020_0000, 32'h0000_0001, 32'h0, "R7 no summary");
    // R8: bank-one summary set but only shortcut sources pending falls through
    apply(32'h0000_0300, 32'h000C_0680, 32'h0000_0001, "R8 fall through to bank two");
    // R9: both summaries set, masked words empty
    apply(32'h0000_0300, 32'h000C_0680, 32'h43E0_0000, "R9 summaries empty");
    // R8: bank-two word ignored without its summary bit
    apply(32'h0000_0100, 32'h0, 32'h0000_0004, "R8 no summary");
    // R4: lowest local among all set
    apply(32'h0000_00FF, 32'h0, 32'h0, "R4 all locals");

    // mixed random patterns reaching every stage
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] b, w1, w2;
      int mode;
      b = $urandom; w1 = $urandom; w2 = $urandom;
      mode = t % 4;
      if (mode >= 1) b[7:0] = 8'h0;
      if (mode >= 2) b[20:10] = 11'h0;
      if (mode == 3) w1 = w1 & 32'h000C_0680;
      if ((t % 7) == 0) w2 = w2 & 32'h43E0_0000;
      apply(b, w1, w2, "R7 R8 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule